// File: doc/BRIEF.md
# UTOPIA Multi-PHY Receive Slave Port

This block is the PHY-side slave of a UTOPIA receive link. It takes cells from per-port cell FIFOs and sends them to an ATM-layer master over a 16-bit word bus, one word for each clock in which the master holds the active-low enable low. Each FIFO is seen through a simple interface: a "complete cell ready" flag, a word presented on its data lines, and a one-cycle pop strobe. The block marks the first word of each cell with start-of-cell. It can generate a parity bit over the word bus. It reports cell-available status to the master.

In multi-PHY mode the master polls the ports by placing a 5-bit address on the bus and reads the polled cell-available flag one clock later. When a cell is not in progress, a cycle with enable high selects the addressed port. Addresses `0` to `NPORT-1` name ports. Every other address, including the idle address `0x1F`, leaves no port selected. A direct-status option also drives one cell-available line per port. In single-PHY mode the address bus is ignored and port 0 is always the source.

The cell length is a static byte count; its lowest bit is dropped, so a cell spans `cfg_cell_bytes[7:1]` words. The transfer engine is a three-state machine:

- `ST_IDLE`: between cells.
- `ST_XFER`: inside a cell, last cycle enabled.
- `ST_HOLD`: inside a cell, paused by enable high.

Its transitions are:

- IDLE→XFER: start a cell.
- IDLE→IDLE: a one-word cell, or no start.
- XFER→XFER and HOLD→XFER: send a word.
- XFER→HOLD and HOLD→HOLD: pause.
- XFER/HOLD→IDLE: the last word is sent.

Top module: `cellbus_rx_slave`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `rx_data`, `rx_soc`, `rx_clav`, `rx_clav_dir` and `fifo_pop` are all 0.
- R2: A word moves only in a cycle where `enb_n` is sampled low and a port is selected. In that cycle, bit p of `fifo_pop` (p = the selected port) is high, and `rx_data` shows the word from `fifo_data[p*16 +: 16]` from the next cycle on. In all other cycles `fifo_pop` is 0 and `rx_data` and `rx_soc` keep their values.
- R3: `rx_soc` is 1 together with the first word of every cell and 0 with every later word.
- R4: A cell is exactly `cfg_cell_bytes[7:1]` words long, and `cfg_cell_bytes[0]` has no effect. After the last word the engine returns to idle.
- R5: `rx_prty` is 0 when `cfg_par_en` is 0. Otherwise it makes the count of ones in {`rx_data`, `rx_prty`} odd when `cfg_par_odd` is 1, and even when `cfg_par_odd` is 0.
- R6: If `enb_n` is high in the middle of a cell, the outputs hold. The word count resumes at the next enabled cycle, with no word skipped or repeated.
- R7: In multi-PHY mode (`cfg_mphy`=1), a cycle with `enb_n` high while no cell is in progress selects port `addr` when `addr` < `NPORT`. Any other address (including `5'h1F`) leaves no port selected. The selection never changes in the middle of a cell.
- R8: In multi-PHY mode, `rx_clav` equals the cell-ready flag of port `addr` one clock after that address is presented, and is 0 one clock after an address that names no port.
- R9: In single-PHY mode (`cfg_mphy`=0), `addr` is ignored. Port 0 is always selected, and `rx_clav` is port 0's cell-ready flag delayed by one clock.
- R10: `rx_clav_dir[p]` is port p's cell-ready flag delayed by one clock when both `cfg_mphy` and `cfg_direct` are 1, and 0 otherwise.
- R11: A new cell starts only if the selected port's `cell_rdy` bit is 1 in the enabled cycle. If it is 0, nothing is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mphy | input | 1 | 1 = multi-PHY address polling and selection |
| cfg_direct | input | 1 | 1 = drive per-port direct cell-available lines (multi-PHY only) |
| cfg_par_en | input | 1 | 1 = generate parity |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_cell_bytes | input | 8 | Cell length in bytes; bit 0 ignored |
| enb_n | input | 1 | Active-low transfer enable from the master |
| addr | input | 5 | Poll / select address, bit 4 is the MSB |
| cell_rdy | input | NPORT | Per-port flag: at least one complete cell not yet started |
| fifo_data | input | NPORT*16 | Per-port head word, port p in bits p*16 +: 16 |
| fifo_pop | output | NPORT | Per-port pop strobe, one cycle per transferred word |
| rx_data | output | 16 | Receive word bus |
| rx_soc | output | 1 | Start of cell |
| rx_prty | output | 1 | Parity over `rx_data` |
| rx_clav | output | 1 | Polled cell-available |
| rx_clav_dir | output | NPORT | Direct per-port cell-available lines |

## Verification
The assertions assume that the configuration inputs change only while reset is asserted, and that the cell length is at least two bytes. The bench changes configuration only inside its reset sequence and uses lengths of 2, 9, 106 and 255 bytes.

The assertions also assume that the FIFO side is truthful: `cell_rdy` is raised only for a port that holds a whole unstarted cell, and the head word on `fifo_data` changes only after a pop. The bench's FIFO model keeps a per-port count of unstarted cells and advances its word pointer only on the pops it predicts. The master side is left free: enable and address are random, including the idle address and addresses that name no port.

// File: rtl/cbrx_pkg.sv
package cbrx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_HOLD = 2'd2
    } xfer_st_t;

endpackage

// File: rtl/cbrx_select.sv
// Port selection, polled cell-available and direct status lines.
module cbrx_select #(
    parameter int NPORT = 4,
    parameter int AW    = 5,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mphy,
    input  logic             cfg_direct,
    input  logic             enb_n,
    input  logic [AW-1:0]    addr,
    input  logic [NPORT-1:0] cell_rdy,
    input  logic             idle,
    output logic [PW-1:0]    sel,
    output logic             sel_ok,
    output logic             clav,
    output logic [NPORT-1:0] clav_dir
);

    logic          hit;
    logic          polled;
    logic [PW-1:0] hit_idx;
    logic [PW-1:0] sel_q;
    logic          selok_q;
    logic          clav_q;

    // decode the address against the port numbers
    always_comb begin
        hit     = 1'b0;
        polled  = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (addr == AW'(i)) begin
                hit     = 1'b1;
                polled  = cell_rdy[i];
                hit_idx = PW'(i);
            end
        end
    end

    // selection is only taken between cells and only with enable high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            selok_q <= 1'b0;
        end else if (idle && enb_n) begin
            sel_q   <= hit ? hit_idx : sel_q;
            selok_q <= hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clav_q <= 1'b0;
        end else begin
            clav_q <= cfg_mphy ? (hit & polled) : cell_rdy[0];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NPORT; g++) begin : g_dir
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) clav_dir[g] <= 1'b0;
                else        clav_dir[g] <= cfg_mphy & cfg_direct & cell_rdy[g];
            end
        end
    endgenerate

    assign sel    = cfg_mphy ? sel_q : '0;
    assign sel_ok = cfg_mphy ? selok_q : 1'b1;
    assign clav   = clav_q;

endmodule

// File: rtl/cbrx_xfer_fsm.sv
// Cell transfer engine: counts words of the selected port's cell.
module cbrx_xfer_fsm
    import cbrx_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int CW    = 8,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int WW   = CW - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enb_n,
    input  logic [PW-1:0]    sel,
    input  logic             sel_ok,
    input  logic [NPORT-1:0] cell_rdy,
    input  logic [WW-1:0]    words,
    output logic             go,
    output logic             first,
    output logic             idle
);

    xfer_st_t      state, state_nxt;
    logic [WW-1:0] cnt;
    logic [WW-1:0] cnt_inc;
    logic          last;

    assign cnt_inc = cnt + 1'b1;
    assign last    = (cnt_inc == words);

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (go) state_nxt = last ? ST_IDLE : ST_XFER;
            ST_XFER: state_nxt = go ? (last ? ST_IDLE : ST_XFER) : ST_HOLD;
            ST_HOLD: if (go) state_nxt = last ? ST_IDLE : ST_XFER;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register and word counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            if (go) cnt <= last ? '0 : cnt_inc;
        end
    end

    // outputs
    always_comb begin
        idle  = (state == ST_IDLE);
        go    = !enb_n && sel_ok && (!idle || cell_rdy[sel]);
        first = (cnt == '0);
    end

endmodule

// File: rtl/cbrx_parity.sv
module cbrx_parity #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] data,
    input  logic          en,
    input  logic          odd,
    output logic          par
);

    assign par = en & ((^data) ^ odd);

endmodule

// File: rtl/cellbus_rx_slave.sv
module cellbus_rx_slave #(
    parameter int NPORT = 4,
    parameter int DW    = 16,
    parameter int AW    = 5,
    parameter int CW    = 8,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_mphy,
    input  logic                cfg_direct,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic [CW-1:0]       cfg_cell_bytes,
    input  logic                enb_n,
    input  logic [AW-1:0]       addr,
    input  logic [NPORT-1:0]    cell_rdy,
    input  logic [NPORT*DW-1:0] fifo_data,
    output logic [NPORT-1:0]    fifo_pop,
    output logic [DW-1:0]       rx_data,
    output logic                rx_soc,
    output logic                rx_prty,
    output logic                rx_clav,
    output logic [NPORT-1:0]    rx_clav_dir
);

    logic [PW-1:0] sel;
    logic          sel_ok;
    logic          go;
    logic          first;
    logic          idle;
    logic          unused_size_lsb;

    assign unused_size_lsb = cfg_cell_bytes[0];

    cbrx_select #(.NPORT(NPORT), .AW(AW)) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mphy  (cfg_mphy),
        .cfg_direct(cfg_direct),
        .enb_n     (enb_n),
        .addr      (addr),
        .cell_rdy  (cell_rdy),
        .idle      (idle),
        .sel       (sel),
        .sel_ok    (sel_ok),
        .clav      (rx_clav),
        .clav_dir  (rx_clav_dir)
    );

    cbrx_xfer_fsm #(.NPORT(NPORT), .CW(CW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enb_n   (enb_n),
        .sel     (sel),
        .sel_ok  (sel_ok),
        .cell_rdy(cell_rdy),
        .words   (cfg_cell_bytes[CW-1:1]),
        .go      (go),
        .first   (first),
        .idle    (idle)
    );

    cbrx_parity #(.DW(DW)) u_par (
        .data(rx_data),
        .en  (cfg_par_en),
        .odd (cfg_par_odd),
        .par (rx_prty)
    );

    genvar g;
    generate
        for (g = 0; g < NPORT; g++) begin : g_pop
            assign fifo_pop[g] = go && (sel == PW'(g));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_soc  <= 1'b0;
        end else if (go) begin
            rx_data <= fifo_data[int'(sel)*DW +: DW];
            rx_soc  <= first;
        end
    end

endmodule

// File: rtl/cbrx_chk.sv
module cbrx_chk #(
    parameter int NPORT = 4,
    parameter int DW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enb_n,
    input logic             cfg_mphy,
    input logic             cfg_direct,
    input logic             cfg_par_en,
    input logic             cfg_par_odd,
    input logic [DW-1:0]    rx_data,
    input logic             rx_soc,
    input logic             rx_prty,
    input logic [NPORT-1:0] rx_clav_dir,
    input logic [NPORT-1:0] fifo_pop
);

    // R2
    pop_needs_enb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop != '0) |-> !enb_n);

    // R2
    pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_pop));

    // R6
    hold_on_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enb_n |=> ($stable(rx_data) && $stable(rx_soc)));

    // R5
    odd_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_par_en && cfg_par_odd) |-> (^{rx_data, rx_prty}));

    // R5
    even_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_par_en && !cfg_par_odd) |-> !(^{rx_data, rx_prty}));

    // R5
    par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_par_en |-> !rx_prty);

    // R9
    single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mphy |-> ((fifo_pop >> 1) == '0));

    // R10
    dir_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_mphy && cfg_direct) |=> (rx_clav_dir == '0));

endmodule

bind cellbus_rx_slave cbrx_chk #(.NPORT(NPORT), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enb_n      (enb_n),
    .cfg_mphy   (cfg_mphy),
    .cfg_direct (cfg_direct),
    .cfg_par_en (cfg_par_en),
    .cfg_par_odd(cfg_par_odd),
    .rx_data    (rx_data),
    .rx_soc     (rx_soc),
    .rx_prty    (rx_prty),
    .rx_clav_dir(rx_clav_dir),
    .fifo_pop   (fifo_pop)
);

// File: tb/test_cellbus_rx_slave.sv
`timescale 1ns/1ps
module test_cellbus_rx_slave;

    localparam int NP = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n;
    logic           cfg_mphy, cfg_direct, cfg_par_en, cfg_par_odd;
    logic [7:0]     cfg_cell_bytes;
    logic           enb_n;
    logic [4:0]     addr;
    logic [NP-1:0]  cell_rdy;
    logic [NP*DW-1:0] fifo_data;
    logic [NP-1:0]  fifo_pop;
    logic [DW-1:0]  rx_data;
    logic           rx_soc, rx_prty, rx_clav;
    logic [NP-1:0]  rx_clav_dir;

    cellbus_rx_slave #(.NPORT(NP), .DW(DW)) i_cellbus_rx_slave (
        .clk(clk), .rst_n(rst_n), .cfg_mphy(cfg_mphy), .cfg_direct(cfg_direct),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_cell_bytes(cfg_cell_bytes), .enb_n(enb_n), .addr(addr),
        .cell_rdy(cell_rdy), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .rx_data(rx_data), .rx_soc(rx_soc), .rx_prty(rx_prty),
        .rx_clav(rx_clav), .rx_clav_dir(rx_clav_dir)
    );

    int total = 0;
    int bad   = 0;

    // reference model state
    int           m_busy, m_cnt, m_sel, m_selv, words, cells_done;
    int           avail[NP];
    int           wptr[NP];
    int           cellno[NP];
    logic [DW-1:0] e_data;
    logic         e_soc, e_clav;
    logic [NP-1:0] e_dir;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word_of(int p, int c, int i);
        return {2'(p), 7'(c), 7'(i)};
    endfunction

    function automatic logic exp_par(logic [DW-1:0] d);
        return cfg_par_en & ((^d) ^ cfg_par_odd);
    endfunction

    task automatic drive_fifo();
        for (int p = 0; p < NP; p++) begin
            fifo_data[p*DW +: DW] = word_of(p, cellno[p], wptr[p]);
            cell_rdy[p] = (avail[p] > 0);
        end
    endtask

    task automatic do_cycle(input logic en_n, input logic [4:0] a);
        int s, sv, was_busy;
        bit go;
        logic [NP-1:0] ep;
        logic [DW-1:0] w;
        string tag;
        enb_n = en_n;
        addr  = a;
        drive_fifo();
        s  = cfg_mphy ? m_sel : 0;
        sv = cfg_mphy ? m_selv : 1;
        go = !en_n && (sv != 0) && ((m_busy != 0) || cell_rdy[s]);
        ep = go ? NP'(1 << s) : '0;
        was_busy = m_busy;
        w = fifo_data[s*DW +: DW];
        #1;
        if (!en_n && !m_busy && sv != 0 && !cell_rdy[s]) tag = "R11";
        else if (cfg_mphy) tag = "R7";
        else tag = "R9";
        chk(fifo_pop == ep, {tag, " pop"}, 32'(fifo_pop), 32'(ep));
        e_clav = cfg_mphy ? ((a < NP) ? cell_rdy[a[1:0]] : 1'b0) : cell_rdy[0];
        e_dir  = (cfg_mphy && cfg_direct) ? cell_rdy : '0;
        @(posedge clk);
        if (go) begin
            e_data = w;
            e_soc  = (m_cnt == 0);
            if (m_cnt == 0) avail[s]--;
            wptr[s]++;
            m_cnt++;
            if (m_cnt == words) begin
                m_cnt = 0; m_busy = 0; wptr[s] = 0; cellno[s]++; cells_done++;
            end else m_busy = 1;
        end
        if (cfg_mphy && en_n && !was_busy) begin
            if (a < NP) begin m_sel = int'(a); m_selv = 1; end
            else m_selv = 0;
        end
        for (int p = 0; p < NP; p++)
            if (($urandom % 8) == 0 && avail[p] < 3) avail[p]++;
        @(negedge clk);
        tag = (was_busy && en_n) ? "R6" : "R2";
        chk(rx_data == e_data, {tag, " data"}, 32'(rx_data), 32'(e_data));
        chk(rx_soc == e_soc, "R3 soc", 32'(rx_soc), 32'(e_soc));
        chk(rx_prty == exp_par(rx_data), "R5 parity", 32'(rx_prty), 32'(exp_par(rx_data)));
        chk(rx_clav == e_clav, cfg_mphy ? "R8 clav" : "R9 clav", 32'(rx_clav), 32'(e_clav));
        chk(rx_clav_dir == e_dir, "R10 dir", 32'(rx_clav_dir), 32'(e_dir));
    endtask

    task automatic run_cfg(input bit mp, input bit dr, input bit pe, input bit po,
                           input logic [7:0] bytes, input int n);
        logic [4:0] a;
        logic en;
        rst_n = 1'b0;
        cfg_mphy = mp; cfg_direct = dr; cfg_par_en = pe; cfg_par_odd = po;
        cfg_cell_bytes = bytes;
        words = int'(bytes[7:1]);   // R4: bit 0 dropped
        m_busy = 0; m_cnt = 0; m_sel = 0; m_selv = 0; cells_done = 0;
        e_data = '0; e_soc = 0; e_clav = 0; e_dir = '0;
        for (int p = 0; p < NP; p++) begin avail[p] = 1; wptr[p] = 0; cellno[p] = 0; end
        enb_n = 1'b1; addr = 5'h1F;
        drive_fifo();
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(rx_data == '0 && rx_soc == 0 && rx_clav == 0 && rx_clav_dir == '0,
            "R1 reset outputs", {15'd0, rx_soc, rx_data}, 32'd0);
        chk(fifo_pop == '0, "R1 reset pop", 32'(fifo_pop), 32'd0);
        rst_n = 1'b1;
        // directed: select port 1, start a cell, pause with other addresses, resume
        avail[1] = 2;
        do_cycle(1'b1, 5'd1);
        do_cycle(1'b0, 5'd3);
        for (int k = 0; k < 3; k++) do_cycle(1'b1, 5'(k + 2));
        do_cycle(1'b1, 5'h1F);
        for (int k = 0; k < 3; k++) do_cycle(1'b0, 5'd0);
        // random traffic
        for (int i = 0; i < n; i++) begin
            en = (($urandom % 10) < 3);
            case ($urandom % 8)
                0:       a = 5'h1F;
                1:       a = 5'(NP + ($urandom % (31 - NP)));
                default: a = 5'($urandom % NP);
            endcase
            do_cycle(en, a);
        end
        // R4: cells of the configured length must have completed
        chk(cells_done > 0, "R4 cells completed", 32'(cells_done), 32'd1);
    endtask

    initial begin
        #4_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        @(negedge clk);
        run_cfg(1'b0, 1'b0, 1'b1, 1'b1, 8'd9,   1500);  // single port, odd, 4 words
        run_cfg(1'b1, 1'b1, 1'b1, 1'b0, 8'd2,   1500);  // multi-PHY, direct, even, 1 word
        run_cfg(1'b1, 1'b0, 1'b0, 1'b1, 8'd106, 2500);  // parity off, 53 words
        run_cfg(1'b1, 1'b1, 1'b1, 1'b1, 8'd255, 3000);  // 127 words, bit 0 ignored
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule